// File: doc/BRIEF.md
# Serial Converter Host Sequencer

This block is the host side of a link to an external 12-bit, 8-channel serial analog-to-digital converter. One pulse on `start_i` with a channel, a range bit, a polarity bit and a 2-bit power/clock code starts a frame. The block lowers chip select and sends an 8-bit command, most significant bit first, on `mosi_o`. It then collects the 12 result bits from `miso_i` and returns them, tagged with their channel, as a single-cycle valid pulse.

The serial clock comes from the system clock. Each low phase and each high phase lasts `HALF_CYC` system cycles, and the clock rests low. The command bit changes with the falling serial edge and the result bit is sampled with the rising edge. A clock code other than `00` selects the host-clocked mode, in which the clock keeps running through the 12 read clocks straight after the command. Code `00` selects the converter-clocked mode. There the serial clock is parked after the command while the strobe input shows the conversion: the strobe first goes low, and its return high means the first result bit is already on the line. If the strobe has not finished within `TMO_CYC` system cycles, the frame is dropped and a timeout pulse is raised.

Top module: `adc_host_ctrl`

## Requirements
- R1: During and after reset, with no request made, `cs_n_o`=1, `sclk_o`=0, `mosi_o`=0, `res_valid_o`=0 and `timeout_o`=0.
- R2: The command byte is sent MSB first as {1, chan[2:0], range, bipolar, pwr[1:0]} (bit 7 is the constant start bit). Each bit is driven from the falling serial edge before its clock, so it stays stable through each high phase, and `mosi_o` is 0 outside the command.
- R3: Chip select goes low in the cycle after `start_i` is taken. The serial clock rests low while chip select is high, and each low and each high phase lasts exactly `HALF_CYC` system cycles.
- R4: With pwr != 00, exactly 20 contiguous serial clocks run: 8 carry the command, and the 12 that follow sample `miso_i` on their rising edges, D11 first.
- R5: After the last falling serial edge of a good frame, `cs_n_o` returns high in the same cycle that `res_valid_o` pulses for exactly one cycle. In that cycle `res_data_o` holds the 12 sampled bits and `res_chan_o` the requested channel.
- R6: With pwr = 00, the serial clock stays low and chip select stays low after the command until `sstrb_i` has been seen low and then high. Then 12 read clocks run, and the first rising edge samples D11.
- R7: With pwr = 00, if the strobe has not completed `TMO_CYC` cycles after the 8th falling edge, `timeout_o` pulses for one cycle, chip select returns high and no valid pulse is given.
- R8: `start_i` has no effect while chip select is low: the running frame, its command and its channel tag are unchanged, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken only when idle |
| chan_i | input | 3 | Channel to convert |
| range_i | input | 1 | Input range select bit |
| bipolar_i | input | 1 | Polarity select bit |
| pwr_i | input | 2 | Power/clock code, 00 = converter-clocked mode |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Command data to the converter |
| miso_i | input | 1 | Result data from the converter |
| sstrb_i | input | 1 | Conversion strobe from the converter |
| res_valid_o | output | 1 | One-cycle result valid pulse |
| res_data_o | output | 12 | Result, D11 in bit 11 |
| res_chan_o | output | 3 | Channel of the result |
| timeout_o | output | 1 | One-cycle strobe timeout pulse |

## Verification
A divider or phase counter that is off by one appears on the pins at the first serial edge of a frame: the clock level departs from the expected square wave within `HALF_CYC` cycles. A bit counter that is off shifts the command or result by a bit, or stretches the frame, and this shows at the 8th falling edge or at the frame's end. A sequencer that mistakes the mode or restarts on a stray request shows in the first cycle where the clock runs while it should be parked, or where chip select stays low too long. A strobe timer that is off moves the timeout pulse by whole cycles, which the per-cycle comparison detects in the cycle it happens.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

    localparam int CMD_BITS = 8;
    localparam int RES_BITS = 12;
    localparam int CHAN_W   = 3;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_WAIT,
        ST_READ
    } host_state_e;

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic              rng;
        logic              bip;
        logic [1:0]        pwr;
    } host_req_t;

    function automatic logic [CMD_BITS-1:0] build_cmd(host_req_t r);
        return {1'b1, r.chan, r.rng, r.bip, r.pwr};
    endfunction

    function automatic logic uses_int_clock(host_req_t r);
        return (r.pwr == 2'b00);
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
module adc_sclk_gen #(
    parameter int HALF_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign tick   = en_i && (cnt_q == LAST);
    assign rise_o = tick && !sclk_o;
    assign fall_o = tick && sclk_o;

    always_ff @(posedge clk) begin
        if (rst || !en_i) begin
            cnt_q  <= '0;
            sclk_o <= 1'b0;
        end else if (tick) begin
            cnt_q  <= '0;
            sclk_o <= !sclk_o;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/adc_strobe_wait.sv
module adc_strobe_wait #(
    parameter int TMO_CYC = 3000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm_i,
    input  logic strobe_i,
    output logic done_o,
    output logic expire_o
);
    localparam int TW = $clog2(TMO_CYC + 1);
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] cnt_q;
    logic          seen_low_q;

    assign done_o   = arm_i && seen_low_q && strobe_i;
    assign expire_o = arm_i && !done_o && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !arm_i) begin
            cnt_q      <= '0;
            seen_low_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (!strobe_i)
                seen_low_q <= 1'b1;
        end
    end
endmodule

// File: rtl/adc_rx_shift.sv
module adc_rx_shift #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             shift_i,
    input  logic             bit_i,
    output logic [WIDTH-1:0] data_o
);
    always_ff @(posedge clk) begin
        if (rst || clr_i)
            data_o <= '0;
        else if (shift_i)
            data_o <= {data_o[WIDTH-2:0], bit_i};
    end
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int HALF_CYC = 4,
    parameter int TMO_CYC  = 3000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic [CHAN_W-1:0]   chan_i,
    input  logic                range_i,
    input  logic                bipolar_i,
    input  logic [1:0]          pwr_i,
    output logic                cs_n_o,
    output logic                sclk_o,
    output logic                mosi_o,
    input  logic                miso_i,
    input  logic                sstrb_i,
    output logic                res_valid_o,
    output logic [RES_BITS-1:0] res_data_o,
    output logic [CHAN_W-1:0]   res_chan_o,
    output logic                timeout_o
);
    localparam int BC_W = $clog2(RES_BITS);
    localparam logic [BC_W-1:0] CMD_LAST = BC_W'(CMD_BITS - 1);
    localparam logic [BC_W-1:0] RES_LAST = BC_W'(RES_BITS - 1);

    host_state_e           state_q;
    host_req_t             req;
    logic [CHAN_W-1:0]     chan_q;
    logic                  int_q;
    logic [CMD_BITS-1:0]   cmd_sr_q;
    logic [BC_W-1:0]       bit_q;
    logic                  sclk_en, s_rise, s_fall;
    logic                  wait_arm, strb_done, strb_expire;
    logic [RES_BITS-1:0]   rx_data;

    assign req      = '{chan: chan_i, rng: range_i, bip: bipolar_i, pwr: pwr_i};
    assign sclk_en  = (state_q == ST_CMD) || (state_q == ST_READ);
    assign wait_arm = (state_q == ST_WAIT);
    assign cs_n_o   = (state_q == ST_IDLE);
    assign mosi_o   = cmd_sr_q[CMD_BITS-1];

    adc_sclk_gen #(.HALF_CYC(HALF_CYC)) u_sclk (
        .clk    (clk),
        .rst    (rst),
        .en_i   (sclk_en),
        .sclk_o (sclk_o),
        .rise_o (s_rise),
        .fall_o (s_fall)
    );

    adc_strobe_wait #(.TMO_CYC(TMO_CYC)) u_wait (
        .clk      (clk),
        .rst      (rst),
        .arm_i    (wait_arm),
        .strobe_i (sstrb_i),
        .done_o   (strb_done),
        .expire_o (strb_expire)
    );

    adc_rx_shift #(.WIDTH(RES_BITS)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .clr_i   ((state_q == ST_IDLE) && start_i),
        .shift_i ((state_q == ST_READ) && s_rise),
        .bit_i   (miso_i),
        .data_o  (rx_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            chan_q      <= '0;
            int_q       <= 1'b0;
            cmd_sr_q    <= '0;
            bit_q       <= '0;
            res_valid_o <= 1'b0;
            res_data_o  <= '0;
            res_chan_o  <= '0;
            timeout_o   <= 1'b0;
        end else begin
            res_valid_o <= 1'b0;
            timeout_o   <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        chan_q   <= req.chan;
                        int_q    <= uses_int_clock(req);
                        cmd_sr_q <= build_cmd(req);
                        bit_q    <= '0;
                        state_q  <= ST_CMD;
                    end
                end
                ST_CMD: begin
                    if (s_fall) begin
                        cmd_sr_q <= {cmd_sr_q[CMD_BITS-2:0], 1'b0};
                        if (bit_q == CMD_LAST) begin
                            bit_q   <= '0;
                            state_q <= int_q ? ST_WAIT : ST_READ;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                ST_WAIT: begin
                    if (strb_done) begin
                        state_q <= ST_READ;
                    end else if (strb_expire) begin
                        state_q   <= ST_IDLE;
                        timeout_o <= 1'b1;
                    end
                end
                ST_READ: begin
                    if (s_fall) begin
                        if (bit_q == RES_LAST) begin
                            state_q     <= ST_IDLE;
                            res_valid_o <= 1'b1;
                            res_data_o  <= rx_data;
                            res_chan_o  <= chan_q;
                        end else begin
                            bit_q <= bit_q + 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/adc_host_ctrl_chk.sv
module adc_host_ctrl_chk
    import adc_host_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n_o,
    input logic              sclk_o,
    input logic              mosi_o,
    input logic              res_valid_o,
    input logic              timeout_o,
    input logic              wait_i,
    input logic [CHAN_W-1:0] chan_i
);
    p_sclk_rest_r3: assert property (@(posedge clk) disable iff (rst)
        cs_n_o |-> !sclk_o);

    p_mosi_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!cs_n_o && !$past(cs_n_o) && !$fell(sclk_o)) |-> $stable(mosi_o));

    p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |=> !res_valid_o);

    p_valid_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        res_valid_o |-> (cs_n_o && !$past(cs_n_o)));

    p_parked_clock_r6: assert property (@(posedge clk) disable iff (rst)
        wait_i |-> !sclk_o);

    p_timeout_clean_r7: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> (cs_n_o && !res_valid_o));

    p_chan_locked_r8: assert property (@(posedge clk) disable iff (rst)
        !cs_n_o |=> (cs_n_o || $stable(chan_i)));
endmodule

bind adc_host_ctrl adc_host_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .res_valid_o (res_valid_o),
    .timeout_o   (timeout_o),
    .wait_i      (wait_arm),
    .chan_i      (chan_q)
);

// File: tb/adc_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_host_ctrl_tb_top;
    localparam int H = 3;
    localparam int T = 200;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [2:0]  chan_i = '0;
    logic        range_i = 1'b0;
    logic        bipolar_i = 1'b0;
    logic [1:0]  pwr_i = '0;
    logic        miso_i = 1'b0;
    logic        sstrb_i = 1'b1;
    logic        cs_n_o, sclk_o, mosi_o, res_valid_o, timeout_o;
    logic [11:0] res_data_o;
    logic [2:0]  res_chan_o;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = !clk;

    adc_host_ctrl #(.HALF_CYC(H), .TMO_CYC(T)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .chan_i(chan_i),
        .range_i(range_i), .bipolar_i(bipolar_i), .pwr_i(pwr_i),
        .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
        .miso_i(miso_i), .sstrb_i(sstrb_i), .res_valid_o(res_valid_o),
        .res_data_o(res_data_o), .res_chan_o(res_chan_o), .timeout_o(timeout_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // frame configuration shared with the converter/reference model
    logic [7:0]  cfg_byte = '0;
    logic [11:0] cfg_word = '0;
    logic [2:0]  cfg_chan = '0;
    bit          cfg_int = 0;
    int          cfg_delay = 0;
    bit          frame_done = 0;

    // model state
    logic        prev_sclk = 1'b0;
    logic [7:0]  rx_byte = '0;
    int nrise = 0, idx = 0, dly = 0, seg = 0, k = 0, w = 0, len = 0;
    bit raise_flag = 0, go_read = 0, rise_e, fall_e;
    logic exp_mosi;

    always @(negedge clk) begin
        if (rst) begin
            prev_sclk = 1'b0; nrise = 0; seg = 0; dly = 0; raise_flag = 0;
        end else begin
            rise_e = sclk_o && !prev_sclk;
            fall_e = !sclk_o && prev_sclk;
            prev_sclk = sclk_o;
            go_read = raise_flag;
            raise_flag = 0;
            if (dly > 0) begin
                dly--;
                if (dly == 0) begin
                    sstrb_i = 1'b1; miso_i = cfg_word[11]; idx = 10; raise_flag = 1;
                end
            end
            if (cs_n_o) begin
                nrise = 0;
                if (seg == 0) sstrb_i = 1'b1;
            end else begin
                if (rise_e) begin
                    if (nrise < 8) rx_byte = {rx_byte[6:0], mosi_o};
                    nrise++;
                end
                if (fall_e) begin
                    if (nrise == 8) begin
                        chk(rx_byte == cfg_byte, "R2", "command byte", rx_byte, cfg_byte);
                        if (cfg_int) begin
                            sstrb_i = 1'b0; dly = cfg_delay;
                        end else begin
                            miso_i = cfg_word[11]; idx = 10;
                        end
                    end else if (nrise > 8) begin
                        miso_i = (idx >= 0) ? cfg_word[idx] : 1'b0;
                        idx--;
                    end
                end
            end

            // cycle-by-cycle reference of the pins
            if (seg == 0 && !cs_n_o) begin seg = 1; k = 0; end
            if (seg == 1 || seg == 3) begin
                len = (seg == 1) ? (cfg_int ? 16*H : 40*H) : 24*H;
                if (k < len) begin
                    exp_mosi = (seg == 1 && k < 16*H) ? cfg_byte[7 - k/(2*H)] : 1'b0;
                    chk(cs_n_o == 1'b0, "R3", "cs low in frame", cs_n_o, 0);
                    chk(sclk_o == ((k/H) % 2), "R3", "sclk phase", sclk_o, (k/H) % 2);
                    chk(mosi_o == exp_mosi, "R2", "mosi bit", mosi_o, exp_mosi);
                    chk(!res_valid_o, "R5", "early valid", res_valid_o, 0);
                    k++;
                end else if (seg == 1 && cfg_int) begin
                    chk(!cs_n_o && !sclk_o, "R6", "enter wait", {cs_n_o, sclk_o}, 0);
                    seg = 2; w = 1;
                end else begin
                    chk(cs_n_o == 1'b1, "R4", "cs high at end", cs_n_o, 1);
                    chk(res_valid_o == 1'b1, "R5", "valid at end", res_valid_o, 1);
                    chk(res_data_o == cfg_word, "R4", "result data", res_data_o, cfg_word);
                    chk(res_chan_o == cfg_chan, "R5", "result channel", res_chan_o, cfg_chan);
                    chk(!timeout_o, "R7", "no timeout", timeout_o, 0);
                    frame_done = 1; seg = 0;
                end
            end else if (seg == 2) begin
                if (go_read) begin
                    chk(!cs_n_o && !sclk_o, "R6", "read start", {cs_n_o, sclk_o}, 0);
                    seg = 3; k = 1;
                end else if (cfg_delay == 0 && w == T) begin
                    chk(timeout_o == 1'b1, "R7", "timeout pulse", timeout_o, 1);
                    chk(cs_n_o == 1'b1, "R7", "cs high on timeout", cs_n_o, 1);
                    chk(!res_valid_o, "R7", "no valid on timeout", res_valid_o, 0);
                    frame_done = 1; seg = 0;
                end else begin
                    chk(!cs_n_o, "R6", "cs held in wait", cs_n_o, 0);
                    chk(!sclk_o, "R6", "sclk parked", sclk_o, 0);
                    chk(!timeout_o, "R7", "early timeout", timeout_o, 0);
                    w++;
                end
            end
        end
    end

    task automatic run_frame(input logic [2:0] ch, input bit rng, input bit bip,
                             input logic [1:0] pwr, input logic [11:0] word,
                             input int delay, input bit poke);
        @(negedge clk);
        cfg_byte = {1'b1, ch, rng, bip, pwr};
        cfg_word = word; cfg_chan = ch;
        cfg_int = (pwr == 2'b00); cfg_delay = delay;
        frame_done = 0;
        chan_i = ch; range_i = rng; bipolar_i = bip; pwr_i = pwr; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0; chan_i = '0; range_i = 1'b0; bipolar_i = 1'b0; pwr_i = '0;
        if (poke) begin
            repeat (5*H) @(negedge clk);
            chan_i = ~ch; pwr_i = ~pwr; start_i = 1'b1;   // R8: must be ignored
            @(negedge clk);
            start_i = 1'b0; chan_i = '0; pwr_i = '0;
        end
        while (!frame_done) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(cs_n_o == 1'b1, "R8", "no extra frame", cs_n_o, 1);
            chk(!res_valid_o && !timeout_o, "R5", "pulse ended", {res_valid_o, timeout_o}, 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(cs_n_o && !sclk_o && !mosi_o && !res_valid_o && !timeout_o, "R1", "in reset",
            {cs_n_o, sclk_o, mosi_o, res_valid_o, timeout_o}, 5'b10000);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(cs_n_o && !sclk_o && !mosi_o && !res_valid_o && !timeout_o, "R1", "after reset",
            {cs_n_o, sclk_o, mosi_o, res_valid_o, timeout_o}, 5'b10000);
        run_frame(3'd5, 1, 0, 2'b11, 12'hA5C, 0, 0);   // R4 host-clocked
        run_frame(3'd0, 0, 1, 2'b01, 12'hFFF, 0, 0);   // R4
        run_frame(3'd7, 1, 1, 2'b10, 12'h001, 0, 1);   // R8 with stray start
        run_frame(3'd3, 0, 0, 2'b00, 12'h3C6, 30, 0);  // R6 converter-clocked
        run_frame(3'd6, 1, 0, 2'b00, 12'h000, 0, 0);   // R7 timeout
        run_frame(3'd2, 0, 1, 2'b00, 12'h800, 1, 1);   // R6 shortest strobe, R8
        run_frame(3'd1, 1, 1, 2'b11, 12'h555, 0, 1);   // R8
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule